// File: doc/BRIEF.md
# DRAM Clock-Enable Power State Tracker

This block follows the low-power state of a double-data-rate DRAM device, one rising clock edge at a time. It registers the clock-enable input, so at every edge it has the level seen at the previous edge and the level present now. It combines that pair with the state held before the edge, a decoded command and a flag that says whether any bank is open. From these it picks a power action and a next state. Refresh execution, bank timing and the data path are outside the block.

The tracker has five named states. IDLE means all banks are closed and ACTIVE means at least one bank is open. PPD is precharge power-down, APD is active power-down and SREF is self refresh. The transitions are: normal operation (IDLE or ACTIVE following the bank flag), power-down entry (IDLE/ACTIVE to PPD or APD), self-refresh entry (IDLE to SREF), maintain (PPD, APD or SREF to itself), power-down exit (PPD to IDLE, APD to ACTIVE) and self-refresh exit (SREF to IDLE). Any combination outside these is illegal. An illegal combination sets a sticky flag and leaves the state unchanged.

A guard stage runs after a self-refresh exit. For a recovery window of `XSR_CYC` edges only DESELECT/NOP may be issued. READ stays blocked until `DLL_CYC` edges have passed, which gives the DLL time to lock again. Entering self refresh clears both counts. A breach of either rule sets a second sticky flag.

Top module: `cke_pwr_tracker`

## Requirements
- R1: After reset the state is IDLE (0), the action is zero, read_ok is 1, and seq_err and guard_err are 0. The previous clock-enable level is taken as high.
- R2: Clock enable high at both edges, in IDLE or ACTIVE, gives action zero. The next state is ACTIVE (1) when bank_open is 1 and IDLE (0) otherwise, for any command. Commands are encoded DESELECT/NOP=0, AUTO REFRESH=1, READ=2, other=3.
- R3: Clock enable low at both edges, in PPD (2), APD (3) or SREF (4), keeps the state for any command and gives action bit 0 (maintain).
- R4: Clock enable going low to high with NOP, in PPD, APD or SREF, gives action bit 1 (exit). PPD returns to IDLE, APD returns to ACTIVE and SREF returns to IDLE.
- R5: Clock enable going high to low with NOP, in IDLE or ACTIVE, enters PPD with action bit 2 when bank_open is 0. It enters APD with action bit 3 when bank_open is 1.
- R6: Clock enable going high to low with AUTO REFRESH, in IDLE or ACTIVE with bank_open 0, enters SREF with action bit 4.
- R7: Any other combination is illegal. It gives action zero, leaves the state unchanged and sets seq_err, which then stays 1 until reset.
- R8: On edges 1 to XSR_CYC after a self-refresh exit edge, any command other than NOP sets guard_err, which stays 1 until reset.
- R9: read_ok is 0 while in SREF and after a self-refresh exit. It rises in time for edge DLL_CYC after the exit, so it reads 1 from the sample after edge DLL_CYC-1.
- R10: A READ issued while read_ok is 0 sets guard_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock-enable level at this edge |
| cmd | input | 2 | Decoded command: 0 NOP, 1 AUTO REFRESH, 2 READ, 3 other |
| bank_open | input | 1 | 1 when any bank is open |
| action | output | 5 | One-hot action of the last edge: bit0 maintain, bit1 exit, bit2 PPD entry, bit3 APD entry, bit4 SREF entry; zero for none or illegal |
| state | output | 3 | Registered state: 0 IDLE, 1 ACTIVE, 2 PPD, 3 APD, 4 SREF |
| read_ok | output | 1 | READ is allowed at the next edge |
| seq_err | output | 1 | Sticky illegal-sequence flag |
| guard_err | output | 1 | Sticky exit-window or early-READ violation flag |

## Verification
Every result of edge n is registered at that edge: state, action and both error flags. The bench drives inputs on the falling edge and samples 2 ns after the next rising edge, so it reads exactly the decision of that edge. read_ok is due one edge earlier than the READ it permits, so the bench checks it after each NOP edge k that follows an exit against the rule k ≥ DLL_CYC-1. For the window tests, the offending command is placed at exact edge offsets just inside and just outside each limit, and the flag is sampled right after that edge.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACTIVE = 3'd1,
        ST_PPD    = 3'd2,
        ST_APD    = 3'd3,
        ST_SREF   = 3'd4
    } pwr_state_e;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_AREF  = 2'd1,
        CMD_READ  = 2'd2,
        CMD_OTHER = 2'd3
    } dram_cmd_e;

    localparam int ACT_W = 5;
    localparam logic [ACT_W-1:0] ACT_NONE  = 5'b00000;
    localparam logic [ACT_W-1:0] ACT_MAINT = 5'b00001;
    localparam logic [ACT_W-1:0] ACT_EXIT  = 5'b00010;
    localparam logic [ACT_W-1:0] ACT_PPD   = 5'b00100;
    localparam logic [ACT_W-1:0] ACT_APD   = 5'b01000;
    localparam logic [ACT_W-1:0] ACT_SREF  = 5'b10000;

    function automatic logic is_low_power(pwr_state_e s);
        return (s == ST_PPD) || (s == ST_APD) || (s == ST_SREF);
    endfunction

endpackage

// File: rtl/cke_state_fsm.sv
module cke_state_fsm
    import cke_pwr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  dram_cmd_e            cmd,
    input  logic                 bank_open,
    output pwr_state_e           state_q,
    output logic [ACT_W-1:0]     action_q,
    output logic                 seq_err_q,
    output logic                 sr_enter,
    output logic                 sr_exit
);

    logic            cke_q;
    pwr_state_e      state_d;
    logic [ACT_W-1:0] action_d;
    logic            bad_d;
    logic            low_now;

    assign low_now = is_low_power(state_q);

    // next-state and action decision for edge n
    always_comb begin
        state_d  = state_q;
        action_d = ACT_NONE;
        bad_d    = 1'b0;
        unique case ({cke_q, cke})
            2'b00: begin
                if (low_now) action_d = ACT_MAINT;
                else         bad_d    = 1'b1;
            end
            2'b01: begin
                if (low_now && cmd == CMD_NOP) begin
                    action_d = ACT_EXIT;
                    state_d  = (state_q == ST_APD) ? ST_ACTIVE : ST_IDLE;
                end else begin
                    bad_d = 1'b1;
                end
            end
            2'b10: begin
                if (!low_now && cmd == CMD_NOP) begin
                    state_d  = bank_open ? ST_APD : ST_PPD;
                    action_d = bank_open ? ACT_APD : ACT_PPD;
                end else if (!low_now && cmd == CMD_AREF && !bank_open) begin
                    state_d  = ST_SREF;
                    action_d = ACT_SREF;
                end else begin
                    bad_d = 1'b1;
                end
            end
            2'b11: begin
                if (!low_now) state_d = bank_open ? ST_ACTIVE : ST_IDLE;
                else          bad_d   = 1'b1;
            end
            default: bad_d = 1'b1;
        endcase
    end

    assign sr_enter = (action_d == ACT_SREF);
    assign sr_exit  = (action_d == ACT_EXIT) && (state_q == ST_SREF);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cke_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            cke_q   <= cke;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            action_q  <= ACT_NONE;
            seq_err_q <= 1'b0;
        end else begin
            action_q  <= action_d;
            seq_err_q <= seq_err_q | bad_d;
        end
    end

    // R2 / R3 / R4 / R5 / R6: the action code is one-hot or zero
    a_r2_action_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(action_q));

    // R7: sticky illegal flag
    a_r7_seq_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err_q |=> seq_err_q);

    // R7: a new illegal flag comes with an unchanged state and no action
    a_r7_hold_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err_q) |-> (state_q == $past(state_q)) && (action_q == ACT_NONE));

    // R3: maintain leaves the state unchanged
    a_r3_maintain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        action_q[0] |-> $stable(state_q));

    // R6: entering self refresh always lands in SREF
    a_r6_sref_entry: assert property (@(posedge clk) disable iff (!rst_n)
        action_q[4] |-> state_q == ST_SREF);

endmodule

// File: rtl/cke_exit_guard.sv
module cke_exit_guard
    import cke_pwr_pkg::*;
#(
    parameter int XSR_CYC = 10,
    parameter int DLL_CYC = 200
) (
    input  logic      clk,
    input  logic      rst_n,
    input  dram_cmd_e cmd,
    input  logic      in_sref,
    input  logic      sr_enter,
    input  logic      sr_exit,
    output logic      read_ok,
    output logic      guard_err_q
);

    localparam int CW = (DLL_CYC > 2) ? $clog2(DLL_CYC) : 2;
    localparam logic [CW-1:0] DLL_LAST = CW'(DLL_CYC - 1);
    localparam logic [CW-1:0] XSR_LIM  = CW'(XSR_CYC);

    logic          dll_wait_q;
    logic [CW-1:0] cnt_q;
    logic          in_window;
    logic          breach;

    // cnt_q holds (edges since exit - 1) before each edge
    assign read_ok   = !dll_wait_q || (!in_sref && cnt_q == DLL_LAST);
    assign in_window = dll_wait_q && !in_sref && (cnt_q < XSR_LIM);
    assign breach    = (in_window && cmd != CMD_NOP) ||
                       (cmd == CMD_READ && !read_ok);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dll_wait_q <= 1'b0;
            cnt_q      <= '0;
        end else if (sr_enter || sr_exit) begin
            dll_wait_q <= 1'b1;
            cnt_q      <= '0;
        end else if (dll_wait_q && !in_sref) begin
            if (cnt_q == DLL_LAST) dll_wait_q <= 1'b0;
            else                   cnt_q      <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) guard_err_q <= 1'b0;
        else        guard_err_q <= guard_err_q | breach;
    end

    // R9: read stays blocked while the device is in self refresh
    a_r9_no_read_in_sref: assert property (@(posedge clk) disable iff (!rst_n)
        in_sref |-> !read_ok);

    // R9: a self-refresh exit leaves read blocked on the next cycle
    a_r9_exit_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit |=> !read_ok);

    // R8 / R10: sticky violation flag
    a_r8_guard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        guard_err_q |=> guard_err_q);

    // R10: an early READ is always flagged
    a_r10_early_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ && !read_ok) |=> guard_err_q);

endmodule

// File: rtl/cke_pwr_tracker.sv
module cke_pwr_tracker #(
    parameter int XSR_CYC = 10,
    parameter int DLL_CYC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  logic [1:0] cmd,
    input  logic       bank_open,
    output logic [4:0] action,
    output logic [2:0] state,
    output logic       read_ok,
    output logic       seq_err,
    output logic       guard_err
);
    import cke_pwr_pkg::*;

    dram_cmd_e  cmd_e;
    pwr_state_e st;
    logic       sr_enter;
    logic       sr_exit;

    assign cmd_e = dram_cmd_e'(cmd);

    cke_state_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .cmd       (cmd_e),
        .bank_open (bank_open),
        .state_q   (st),
        .action_q  (action),
        .seq_err_q (seq_err),
        .sr_enter  (sr_enter),
        .sr_exit   (sr_exit)
    );

    cke_exit_guard #(
        .XSR_CYC (XSR_CYC),
        .DLL_CYC (DLL_CYC)
    ) guard_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd_e),
        .in_sref     (st == ST_SREF),
        .sr_enter    (sr_enter),
        .sr_exit     (sr_exit),
        .read_ok     (read_ok),
        .guard_err_q (guard_err)
    );

    assign state = st;

endmodule

// File: tb/cke_pwr_tracker_tb.sv
`timescale 1ns/1ps
module cke_pwr_tracker_tb_top;

    localparam int XSR = 4;
    localparam int DLL = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic [1:0] cmd = 2'd0;
    logic       bank_open = 1'b0;
    logic [4:0] action;
    logic [2:0] state;
    logic       read_ok;
    logic       seq_err;
    logic       guard_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cke_pwr_tracker #(.XSR_CYC(XSR), .DLL_CYC(DLL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank_open(bank_open),
        .action(action), .state(state), .read_ok(read_ok),
        .seq_err(seq_err), .guard_err(guard_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cke = 1'b1; cmd = 2'd0; bank_open = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive at the falling edge, sample 2 ns after the rising edge
    task automatic step(input logic c, input logic [1:0] m, input logic b);
        @(negedge clk);
        cke = c; cmd = m; bank_open = b;
        @(posedge clk);
        #2;
    endtask

    task automatic goto_state(input int s);
        case (s)
            0: step(1'b1, 2'd0, 1'b0);
            1: step(1'b1, 2'd0, 1'b1);
            2: begin step(1'b1, 2'd0, 1'b0); step(1'b0, 2'd0, 1'b0); end
            3: begin step(1'b1, 2'd0, 1'b1); step(1'b0, 2'd0, 1'b1); end
            default: begin step(1'b1, 2'd0, 1'b0); step(1'b0, 2'd1, 1'b0); end
        endcase
    endtask

    task automatic sref_and_exit();
        do_reset();
        step(1'b1, 2'd0, 1'b0);
        step(1'b0, 2'd1, 1'b0);
        step(1'b1, 2'd0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ns, ea, eb;
        logic lowp, prev;

        // R1 reset state
        do_reset();
        #2;
        chk("R1 state", state, 0);
        chk("R1 action", action, 0);
        chk("R1 read_ok", read_ok, 1);
        chk("R1 seq_err", seq_err, 0);
        chk("R1 guard_err", guard_err, 0);

        // sweep: every state x cke x cmd x bank_open
        for (int s = 0; s < 5; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int b = 0; b < 2; b++) begin
                        do_reset();
                        goto_state(s);
                        step(c[0], m[1:0], b[0]);
                        lowp = (s >= 2);
                        prev = !lowp;
                        ns = s; ea = 0; eb = 0;
                        if (!prev && c == 0) begin
                            if (lowp) ea = 1; else eb = 1;
                        end else if (!prev && c == 1) begin
                            if (lowp && m == 0) begin
                                ea = 2; ns = (s == 3) ? 1 : 0;
                            end else eb = 1;
                        end else if (prev && c == 0) begin
                            if (!lowp && m == 0) begin
                                ns = b ? 3 : 2; ea = b ? 8 : 4;
                            end else if (!lowp && m == 1 && b == 0) begin
                                ns = 4; ea = 16;
                            end else eb = 1;
                        end else begin
                            if (!lowp) ns = b; else eb = 1;
                        end
                        // tags by case: R2 hi/hi, R3 lo/lo, R4 exit, R5 PD entry, R6 SR entry, R7 illegal
                        chk($sformatf("R2-R7 sweep state s%0d c%0d m%0d b%0d", s, c, m, b), state, ns);
                        chk($sformatf("R2-R7 sweep action s%0d c%0d m%0d b%0d", s, c, m, b), action, ea);
                        chk($sformatf("R7 sweep seq_err s%0d c%0d m%0d b%0d", s, c, m, b), seq_err, eb);
                    end
                end
            end
        end

        // R7 stickiness and clearing by reset
        do_reset();
        step(1'b1, 2'd0, 1'b0);
        step(1'b0, 2'd2, 1'b0);
        chk("R7 illegal sets flag", seq_err, 1);
        chk("R7 illegal keeps IDLE", state, 0);
        step(1'b1, 2'd0, 1'b0);
        step(1'b1, 2'd0, 1'b1);
        chk("R7 flag stays", seq_err, 1);
        chk("R2 state after legal", state, 1);
        do_reset();
        #2;
        chk("R7 cleared by reset", seq_err, 0);

        // R9 read_ok in SREF and after exit
        do_reset();
        step(1'b1, 2'd0, 1'b0);
        step(1'b0, 2'd1, 1'b0);
        chk("R9 read_ok in SREF", read_ok, 0);
        step(1'b1, 2'd0, 1'b0);
        chk("R9 read_ok at exit", read_ok, 0);
        for (int k = 1; k <= DLL + 2; k++) begin
            step(1'b1, 2'd0, 1'b0);
            chk($sformatf("R9 read_ok after edge %0d", k), read_ok, (k >= DLL - 1) ? 1 : 0);
        end
        chk("R8 no violation on NOPs", guard_err, 0);

        // R8 command at last window edge
        sref_and_exit();
        for (int k = 1; k < XSR; k++) step(1'b1, 2'd0, 1'b0);
        chk("R8 clean before window end", guard_err, 0);
        step(1'b1, 2'd3, 1'b0);
        chk("R8 other inside window", guard_err, 1);
        step(1'b1, 2'd0, 1'b0);
        chk("R8 flag sticky", guard_err, 1);

        // R8 command just past the window
        sref_and_exit();
        for (int k = 1; k <= XSR; k++) step(1'b1, 2'd0, 1'b0);
        step(1'b1, 2'd3, 1'b0);
        chk("R8 other after window", guard_err, 0);

        // R10 READ one edge early and exactly on time
        sref_and_exit();
        for (int k = 1; k < DLL - 1; k++) step(1'b1, 2'd0, 1'b0);
        step(1'b1, 2'd2, 1'b0);
        chk("R10 READ at edge DLL-1", guard_err, 1);

        sref_and_exit();
        for (int k = 1; k < DLL; k++) step(1'b1, 2'd0, 1'b0);
        step(1'b1, 2'd2, 1'b0);
        chk("R10 READ at edge DLL", guard_err, 0);

        // R10 READ with no prior self refresh
        do_reset();
        step(1'b1, 2'd2, 1'b0);
        chk("R10 READ after reset", guard_err, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule